// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small 32-bit processor that fetches, decodes, executes and retires one instruction on every rising clock edge. It runs nine instructions: word load, word store, a set of register-register arithmetic and logic operations (add, subtract, and, or, signed set-less-than), a branch taken on equal operands, and an absolute jump. The core contains a program counter, a word-organised instruction store and data store, a 32-entry register file with two read ports and one write port, an immediate sign extender, an ALU with a zero flag, a main decoder and a two-level ALU function decoder.

Both stores are synthesizable arrays that the surrounding test environment fills before reset is released. The only outputs are debug taps. One tap shows the current program counter. The others show the register write that the most recent clock edge committed. A system model uses these taps to follow execution without probing inside the core.

Top module: `sc_core`

## Requirements
- R1: While `rst` is sampled high on a rising edge, the next state has `dbg_pc` = 0 and `dbg_we` = 0.
- R2: Any instruction that is neither a branch (opcode 000100) nor a jump (opcode 000010) moves the program counter to PC+4.
- R3: Register-format instructions (opcode 000000) write rd (bits 15:11) with rs (25:21) combined with rt (20:16), chosen by funct (5:0): 100000 add, 100010 subtract, 100100 and, 100101 or.
- R4: Funct 101010 writes 1 to rd when rs is less than rt as signed two's-complement values, and writes 0 otherwise.
- R5: Load (opcode 100011) writes rt with the data word at byte address rs + sign-extended imm[15:0]. The word index is address bits above bit 1.
- R6: Store (opcode 101011) writes rt to the data word at rs + sign-extended imm[15:0] and leaves every register unchanged (`dbg_we` = 0).
- R7: Branch (opcode 000100) sets PC to PC+4+(sign-extended imm << 2) when rs equals rt, and to PC+4 otherwise.
- R8: Jump (opcode 000010) sets PC to {PC+4[31:28], instr[25:0], 2'b00}.
- R9: Register 0 always reads as zero. A write aimed at it has no effect and is not reported on the tap (`dbg_we` stays 0).
- R10: Negative 16-bit offsets extend with their sign, so load/store addressing and branches can move backwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pc | output | 32 | Current program counter (byte address) |
| dbg_we | output | 1 | A register write was committed at the last edge |
| dbg_waddr | output | 5 | Destination register of that write |
| dbg_wdata | output | 32 | Value written |

## Verification
The bound checker watches properties on every cycle. It checks the sequential PC step, branch and jump targets against the operands, that stores and writes to register 0 are never reported, that register 0 reads zero, and that a set-less-than result has one bit. Only the bench scenarios can show that arithmetic results, loaded values and the memory contents left by a store are correct. To do this, a behavioural model runs the same hand-assembled program, and its results are compared at the taps on every cycle. That program includes a store followed by a load of the same word, signed comparisons with a negative operand, and a backward branch.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN  = 32;
  localparam int NREGS = 32;
  localparam int RAW   = $clog2(NREGS);

  localparam logic [5:0] OPC_REG  = 6'b000000;
  localparam logic [5:0] OPC_JMP  = 6'b000010;
  localparam logic [5:0] OPC_BEQ  = 6'b000100;
  localparam logic [5:0] OPC_LOAD = 6'b100011;
  localparam logic [5:0] OPC_STOR = 6'b101011;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_fn_e;

  typedef struct packed {
    logic       dst_rd;
    logic       use_imm;
    logic       wb_mem;
    logic       reg_wr;
    logic       mem_wr;
    logic       is_br;
    logic       is_jmp;
    logic [1:0] alu_cls;
  } ctl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctl_t       ctl,
  output alu_fn_e    alu_fn
);
  always_comb begin
    ctl = '0;
    case (opcode)
      OPC_REG:  begin ctl.dst_rd = 1'b1; ctl.reg_wr = 1'b1; ctl.alu_cls = 2'b10; end
      OPC_LOAD: begin ctl.use_imm = 1'b1; ctl.wb_mem = 1'b1; ctl.reg_wr = 1'b1; end
      OPC_STOR: begin ctl.use_imm = 1'b1; ctl.mem_wr = 1'b1; end
      OPC_BEQ:  begin ctl.is_br = 1'b1; ctl.alu_cls = 2'b01; end
      OPC_JMP:  ctl.is_jmp = 1'b1;
      default:  ;
    endcase
  end

  always_comb begin
    case (ctl.alu_cls)
      2'b00:   alu_fn = ALU_ADD;
      2'b01:   alu_fn = ALU_SUB;
      default: begin
        case (funct)
          FN_SUB:  alu_fn = ALU_SUB;
          FN_AND:  alu_fn = ALU_AND;
          FN_OR:   alu_fn = ALU_OR;
          FN_SLT:  alu_fn = ALU_SLT;
          default: alu_fn = ALU_ADD;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    case (fn)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int N = 32,
  parameter int W = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  logic [W-1:0] rf [N];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) rf[waddr] <= wdata;
  end

  assign rd1 = (ra1 == '0) ? '0 : rf[ra1];
  assign rd2 = (ra2 == '0) ? '0 : rf[ra2];
endmodule

// File: rtl/sc_ram.sv
module sc_ram #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] dbg_pc,
  output logic            dbg_we,
  output logic [RAW-1:0]  dbg_waddr,
  output logic [XLEN-1:0] dbg_wdata
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] pc, pc_plus4, br_tgt, jmp_tgt, pc_next;
  logic [XLEN-1:0] instr, imm_ext, rs_val, rt_val, alu_b, alu_y, mem_q, wb_val;
  logic [RAW-1:0]  rs_a, rt_a, rd_a, wr_a;
  logic            alu_zero;
  ctl_t            ctl;
  alu_fn_e         alu_fn;

  sc_ram #(.DEPTH(IMEM_WORDS), .W(XLEN)) u_imem (
    .clk(clk), .we(1'b0), .addr(pc[IAW+1:2]), .wdata('0), .rdata(instr)
  );

  assign rs_a    = instr[25:21];
  assign rt_a    = instr[20:16];
  assign rd_a    = instr[15:11];
  assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};

  sc_ctrl u_ctrl (
    .opcode(instr[31:26]), .funct(instr[5:0]), .ctl(ctl), .alu_fn(alu_fn)
  );

  assign wr_a = ctl.dst_rd ? rd_a : rt_a;

  sc_regfile #(.N(NREGS), .W(XLEN)) u_rf (
    .clk(clk), .we(ctl.reg_wr), .waddr(wr_a), .wdata(wb_val),
    .ra1(rs_a), .ra2(rt_a), .rd1(rs_val), .rd2(rt_val)
  );

  assign alu_b = ctl.use_imm ? imm_ext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a(rs_val), .b(alu_b), .fn(alu_fn), .y(alu_y), .zero(alu_zero)
  );

  sc_ram #(.DEPTH(DMEM_WORDS), .W(XLEN)) u_dmem (
    .clk(clk), .we(ctl.mem_wr), .addr(alu_y[DAW+1:2]), .wdata(rt_val), .rdata(mem_q)
  );

  assign wb_val   = ctl.wb_mem ? mem_q : alu_y;
  assign pc_plus4 = pc + XLEN'(4);
  assign br_tgt   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign jmp_tgt  = {pc_plus4[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctl.is_jmp)                pc_next = jmp_tgt;
    else if (ctl.is_br && alu_zero) pc_next = br_tgt;
    else                           pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      dbg_we    <= 1'b0;
      dbg_waddr <= '0;
      dbg_wdata <= '0;
    end else begin
      pc        <= pc_next;
      dbg_we    <= ctl.reg_wr && (wr_a != '0);
      dbg_waddr <= wr_a;
      dbg_wdata <= wb_val;
    end
  end

  assign dbg_pc = pc;

  logic unused_bits;
  assign unused_bits = ^{pc[1:0], alu_y[XLEN-1:DAW+2], alu_y[1:0], instr[10:6],
                         imm_ext[XLEN-1:XLEN-2]};
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] pc,
  input logic            we,
  input logic [RAW-1:0]  waddr,
  input logic [XLEN-1:0] wdata,
  input logic [XLEN-1:0] instr,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] rt_val
);
  logic [5:0]      opc;
  logic [XLEN-1:0] offs;
  logic            rst_q;

  assign opc  = instr[31:26];
  assign offs = {{(XLEN-18){instr[15]}}, instr[15:0], 2'b00};

  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk) begin
    if (rst_q === 1'b1) begin
      p_reset_state_r1: assert (pc == '0 && !we)
        else $error("reset state wrong");
    end
  end

  p_seq_pc_r2: assert property (@(posedge clk) disable iff (rst)
    (opc != OPC_BEQ && opc != OPC_JMP) |=> pc == $past(pc) + 32'd4);

  p_slt_bit_r4: assert property (@(posedge clk) disable iff (rst)
    (opc == OPC_REG && instr[5:0] == FN_SLT && instr[15:11] != '0)
      |=> (we && wdata[XLEN-1:1] == '0));

  p_store_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (opc == OPC_STOR) |=> !we);

  p_beq_taken_r7: assert property (@(posedge clk) disable iff (rst)
    (opc == OPC_BEQ && rs_val == rt_val) |=> pc == $past(pc) + 32'd4 + $past(offs));

  p_beq_fall_r7: assert property (@(posedge clk) disable iff (rst)
    (opc == OPC_BEQ && rs_val != rt_val) |=> pc == $past(pc) + 32'd4);

  p_jump_r8: assert property (@(posedge clk) disable iff (rst)
    (opc == OPC_JMP) |=> pc[27:0] == {$past(instr[25:0]), 2'b00});

  p_zero_read_r9: assert property (@(posedge clk) disable iff (rst)
    (instr[25:21] == '0) |-> rs_val == '0);

  p_zero_write_r9: assert property (@(posedge clk) disable iff (rst)
    we |-> waddr != '0);
endmodule

bind sc_core sc_core_chk u_chk (
  .clk(clk), .rst(rst), .pc(dbg_pc), .we(dbg_we), .waddr(dbg_waddr),
  .wdata(dbg_wdata), .instr(instr), .rs_val(rs_val), .rt_val(rt_val)
);

// File: tb/test_sc_core.sv
module test_sc_core;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dbg_pc, dbg_wdata;
  logic        dbg_we;
  logic [4:0]  dbg_waddr;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  logic [31:0] prog  [WORDS];
  logic [31:0] m_mem [WORDS];
  logic [31:0] m_reg [32];
  logic [31:0] m_pc;

  sc_core i_sc_core (
    .clk(clk), .rst(rst), .dbg_pc(dbg_pc), .dbg_we(dbg_we),
    .dbg_waddr(dbg_waddr), .dbg_wdata(dbg_wdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] rr(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'b0, 5'(rs), 5'(rt), 5'(rd), 5'b0, fn};
  endfunction
  function automatic logic [31:0] ii(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] rdreg(input logic [4:0] a);
    return (a == 0) ? 32'd0 : m_reg[a];
  endfunction

  task automatic reset_check(input string when);
    vectors++;
    if (dbg_pc !== 32'd0 || dbg_we !== 1'b0) begin
      fails++;
      $display("FAIL R1 %s: pc=%h we=%b expected pc=0 we=0", when, dbg_pc, dbg_we);
    end
  endtask

  task automatic step_and_compare();
    logic [31:0] ins, a, b, sx, npc, wv;
    logic [4:0]  wa;
    logic        we_e;
    string       tag;
    ins  = prog[m_pc[7:2]];
    a    = rdreg(ins[25:21]);
    b    = rdreg(ins[20:16]);
    sx   = {{16{ins[15]}}, ins[15:0]};
    npc  = m_pc + 4;
    we_e = 0; wa = 0; wv = 0; tag = "R2";
    case (ins[31:26])
      6'b000000: begin
        we_e = 1; wa = ins[15:11];
        case (ins[5:0])
          6'b100000: begin wv = a + b; tag = "R3"; end
          6'b100010: begin wv = a - b; tag = "R3"; end
          6'b100100: begin wv = a & b; tag = "R3"; end
          6'b100101: begin wv = a | b; tag = "R3"; end
          6'b101010: begin wv = ($signed(a) < $signed(b)) ? 1 : 0; tag = "R4"; end
          default:   begin wv = a + b; tag = "R3"; end
        endcase
        if (wa == 0 || ins[25:21] == 0) tag = "R9";
      end
      6'b100011: begin
        we_e = 1; wa = ins[20:16];
        wv = m_mem[(a + sx) >> 2];
        tag = ins[15] ? "R10" : "R5";
      end
      6'b101011: begin
        m_mem[(a + sx) >> 2] = b;
        tag = ins[15] ? "R10" : "R6";
      end
      6'b000100: begin
        if (a == b) npc = m_pc + 4 + (sx << 2);
        tag = ins[15] ? "R10" : "R7";
      end
      6'b000010: begin
        npc = {npc[31:28], ins[25:0], 2'b00};
        tag = "R8";
      end
      default: ;
    endcase
    if (wa == 0) we_e = 0;
    if (we_e) m_reg[wa] = wv;
    m_pc = npc;
    vectors++;
    if (dbg_pc !== npc || dbg_we !== we_e ||
        (we_e && (dbg_waddr !== wa || dbg_wdata !== wv))) begin
      fails++;
      $display("FAIL %s: pc=%h we=%b wa=%0d wd=%h expected pc=%h we=%b wa=%0d wd=%h",
               tag, dbg_pc, dbg_we, dbg_waddr, dbg_wdata, npc, we_e, wa, wv);
    end
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) begin prog[i] = 32'd0; m_mem[i] = 32'd0; end
    for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
    m_mem[0] = 32'd5; m_mem[1] = 32'hFFFF_FFFD; m_mem[2] = 32'h1234_5678; m_mem[3] = 32'd7;
    prog[0]  = ii(6'b100011, 0, 1, 16'd0);      // R5 lw r1
    prog[1]  = ii(6'b100011, 0, 2, 16'd4);      // r2 = -3
    prog[2]  = ii(6'b100011, 0, 3, 16'd8);
    prog[3]  = rr(1, 2, 4, 6'b100000);          // R3 add
    prog[4]  = rr(1, 2, 5, 6'b100010);          // R3 sub
    prog[5]  = rr(3, 2, 6, 6'b100100);          // R3 and
    prog[6]  = rr(3, 1, 7, 6'b100101);          // R3 or
    prog[7]  = rr(2, 1, 8, 6'b101010);          // R4 -3 < 5
    prog[8]  = rr(1, 2, 9, 6'b101010);          // R4 5 < -3 false
    prog[9]  = rr(1, 1, 0, 6'b100000);          // R9 write r0 ignored
    prog[10] = rr(0, 0, 10, 6'b100000);         // R9 r0 reads zero
    prog[11] = ii(6'b101011, 0, 5, 16'd12);     // R6 sw
    prog[12] = ii(6'b100011, 0, 11, 16'd12);    // R5 read back
    prog[13] = ii(6'b100011, 11, 12, 16'hFFFC); // R10 negative load offset
    prog[14] = ii(6'b101011, 5, 3, 16'hFFF8);   // R10 negative store offset
    prog[15] = ii(6'b100011, 0, 13, 16'd0);
    prog[16] = ii(6'b000100, 1, 2, 16'd5);      // R7 not taken
    prog[17] = ii(6'b000100, 1, 1, 16'd2);      // R7 taken
    prog[18] = rr(1, 1, 14, 6'b100000);
    prog[19] = rr(1, 1, 14, 6'b100000);
    prog[20] = rr(0, 1, 15, 6'b100010);
    prog[21] = ii(6'b000100, 10, 0, 16'd1);
    prog[22] = rr(1, 1, 14, 6'b100000);
    prog[23] = {6'b000010, 26'd25};             // R8 jump
    prog[24] = rr(1, 1, 14, 6'b100000);
    prog[25] = ii(6'b000100, 0, 0, 16'hFFFD);   // R10 backward branch
    for (int i = 0; i < WORDS; i++) begin
      i_sc_core.u_imem.mem[i] = prog[i];
      i_sc_core.u_dmem.mem[i] = m_mem[i];
    end
    m_pc = 32'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    reset_check("initial");
    rst = 1'b0;
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      step_and_compare();
    end
    rst = 1'b1;
    repeat (2) @(negedge clk);
    reset_check("mid-run");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule